// File: doc/BRIEF.md
# Scalar Bit-Scan and Quad-Mask Unit

This unit evaluates one scalar bit-scan or quad-mask operation per cycle. The operand is 64 bits wide, or 32 bits wide with the upper half ignored, and a 3-bit opcode picks the operation. There are four search operations that locate a bit: the lowest set bit, the lowest clear bit, the leading position counted down from the MSB, and the run of bits that match the sign bit. There is a zero counter. There are also two mask operations that work on 4-bit groups of an execution mask: one expands each active group to all ones, and the other packs each group down to a single bit.

The result is registered. A search returns a signed 32-bit index or count. When nothing is found it returns -1, driven as all ones in bits 31:0. A mask operation returns a value of operand width. A request is presented with `in_valid`, and the result appears one cycle later with `out_valid`.

Top module: `bitscan_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_result` is all zeros.
- R2: `out_valid` equals `in_valid` of the previous cycle. `out_result` is loaded only when `in_valid` is 1, and it holds its value in every other cycle.
- R3: Index and count results occupy bits 31:0 as a two's-complement number, and bits 63:32 are zero. A "none" result is 32'hFFFF_FFFF in bits 31:0.
- R4: Opcode 0 returns the position of the lowest set bit, or none when the operand is zero.
- R5: Opcode 1 returns the position of the lowest clear bit, or none when the operand is all ones across the active width.
- R6: Opcode 2 returns the active width minus the number of set bits.
- R7: Opcode 3 returns (active width − 1 − position of the highest set bit), or none when the operand is zero.
- R8: Opcode 4 scans from the MSB of the active width toward bit 0. It returns how many bits equal the sign bit before the first bit that differs, or none when the operand is all zeros or all ones.
- R9: Opcode 5 returns a mask in which every 4-bit group (group k is bits 4k+3..4k) that has any bit set becomes 4'hF, and every other group is zero.
- R10: Opcode 6 returns bit k = 1 exactly when group k of the operand is non-zero. All bits above the last group are zero: above bit 15 in 64-bit mode, above bit 7 in 32-bit mode.
- R11: When `in_wide` is 0, the active width is 32 and operand bits 63:32 are ignored. Every result then has bits 63:32 equal to zero.
- R12: Opcode 7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| in_opcode | input | 3 | Operation select |
| in_operand | input | 64 | Operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 64 | Registered index, count or mask |

## Verification
Each search is tried with three kinds of operand. A single isolated bit near either end separates low-side indexing from high-side indexing. An operand of all zeros or all ones must produce the none code and not a wrapped index. Where it matters, the search is repeated in 32-bit mode with garbage in the upper half, which shows whether the active width and the sign position move with `in_wide`. The sign-run scan is tried with both a positive and a negative sign, which shows whether matching bits are skipped rather than set bits. The quad operations use sparse groups in both halves, which shows that grouping and packing order are correct.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    typedef enum logic [2:0] {
        OP_LOW_ONE   = 3'd0,
        OP_LOW_ZERO  = 3'd1,
        OP_ZERO_CNT  = 3'd2,
        OP_LEAD      = 3'd3,
        OP_SIGN_RUN  = 3'd4,
        OP_QUAD_FILL = 3'd5,
        OP_QUAD_PACK = 3'd6,
        OP_NONE      = 3'd7
    } bsq_op_e;

    localparam int IDX_W  = 32;
    localparam int NSCAN  = 4;

endpackage

// File: rtl/bsq_low_finder.sv
module bsq_low_finder #(
    parameter int W  = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = i[IW-1:0];
        end
    end

    always_comb begin
        if (found) begin
            a_hit_is_set_r4: assert (vec[idx] == 1'b1);
        end
    end
endmodule

// File: rtl/bsq_popcount.sv
module bsq_popcount #(
    parameter int W  = 64,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + {{(CW-1){1'b0}}, vec[i]};
        end
    end
endmodule

// File: rtl/bsq_quad.sv
module bsq_quad #(
    parameter int W  = 64,
    parameter int G  = 4,
    localparam int NG = W / G
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] fill,
    output logic [W-1:0] pack
);
    logic [NG-1:0] grp_any;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign grp_any[g]       = |vec[g*G +: G];
        assign fill[g*G +: G]   = {G{grp_any[g]}};
    end

    assign pack = {{(W-NG){1'b0}}, grp_any};
endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit
    import bsq_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int GRP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_wide,
    input  logic [2:0]        in_opcode,
    input  logic [DATA_W-1:0] in_operand,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int HALF_W = DATA_W / 2;
    localparam int SW     = $clog2(DATA_W);
    localparam int CW     = $clog2(DATA_W + 1);
    localparam int NGRP   = DATA_W / GRP_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] op_e, width_mask, diff_v;
    logic              sign_b;
    logic [DATA_W-1:0] scan_in [NSCAN];
    logic              scan_found [NSCAN];
    logic [SW-1:0]     scan_idx [NSCAN];
    logic [CW-1:0]     ones_cnt;
    logic [DATA_W-1:0] quad_fill, quad_pack;

    function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v,
                                               input logic wide);
        logic [DATA_W-1:0] r;
        r = '0;
        if (wide) begin
            for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
        end else begin
            for (int i = 0; i < HALF_W; i++) r[i] = v[HALF_W-1-i];
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] as_index(input logic found,
                                                   input logic [SW-1:0] idx);
        logic [IDX_W-1:0] v;
        v = found ? {{(IDX_W-SW){1'b0}}, idx} : {IDX_W{1'b1}};
        return {{(DATA_W-IDX_W){1'b0}}, v};
    endfunction

    always_comb begin
        width_mask = in_wide ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        op_e       = in_operand & width_mask;
        sign_b     = in_wide ? in_operand[DATA_W-1] : in_operand[HALF_W-1];
        diff_v     = (op_e ^ {DATA_W{sign_b}}) & width_mask;
        scan_in[0] = op_e;
        scan_in[1] = ~op_e & width_mask;
        scan_in[2] = flip(op_e, in_wide);
        scan_in[3] = flip(diff_v, in_wide);
    end

    for (genvar s = 0; s < NSCAN; s++) begin : g_scan
        bsq_low_finder #(.W(DATA_W)) u_find (
            .vec   (scan_in[s]),
            .found (scan_found[s]),
            .idx   (scan_idx[s])
        );
    end

    bsq_popcount #(.W(DATA_W)) u_pop (
        .vec (op_e),
        .cnt (ones_cnt)
    );

    bsq_quad #(.W(DATA_W), .G(GRP_W)) u_quad (
        .vec  (op_e),
        .fill (quad_fill),
        .pack (quad_pack)
    );

    always_comb begin
        logic [IDX_W-1:0] act_w;
        logic [IDX_W-1:0] zeros;
        st_d  = st_q;
        act_w = in_wide ? IDX_W'(DATA_W) : IDX_W'(HALF_W);
        zeros = act_w - {{(IDX_W-CW){1'b0}}, ones_cnt};
        st_d.vld = in_valid;
        if (in_valid) begin
            case (bsq_op_e'(in_opcode))
                OP_LOW_ONE:   st_d.res = as_index(scan_found[0], scan_idx[0]);
                OP_LOW_ZERO:  st_d.res = as_index(scan_found[1], scan_idx[1]);
                OP_ZERO_CNT:  st_d.res = {{(DATA_W-IDX_W){1'b0}}, zeros};
                OP_LEAD:      st_d.res = as_index(scan_found[2], scan_idx[2]);
                OP_SIGN_RUN:  st_d.res = as_index(scan_found[3], scan_idx[3]);
                OP_QUAD_FILL: st_d.res = quad_fill;
                OP_QUAD_PACK: st_d.res = quad_pack;
                default:      st_d.res = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result)));
    p_narrow_upper_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> (out_result[DATA_W-1:HALF_W] == '0));
    p_pack_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 3'd6) |=> (out_result[DATA_W-1:NGRP] == '0));
    p_fill_groups_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 3'd5) |=> (($countones(out_result) % GRP_W) == 0));
    p_none_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 3'd7) |=> (out_result == '0));
    p_index_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode <= 3'd4) |=> (out_result[DATA_W-1:IDX_W] == '0));
endmodule

// File: tb/bitscan_unit_tb.sv
module bitscan_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_wide = 1'b0;
    logic [2:0]  in_opcode = 3'd0;
    logic [63:0] in_operand = '0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [63:0] NONE = 64'h0000_0000_FFFF_FFFF;

    always #5 clk = ~clk;

    bitscan_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_opcode(in_opcode), .in_operand(in_operand),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic compare(input string tag, input logic [63:0] act,
                           input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic w, input logic [2:0] op,
                          input logic [63:0] v, input logic [63:0] exp);
        @(negedge clk);
        in_valid = 1'b1; in_wide = w; in_opcode = op; in_operand = v;
        @(negedge clk);
        in_valid = 1'b0;
        compare({tag, " valid"}, {63'd0, out_valid}, 64'd1);
        compare(tag, out_result, exp);
    endtask

    task automatic t_reset;
        compare("R1 valid", {63'd0, out_valid}, 64'd0);
        compare("R1 result", out_result, 64'd0);
    endtask

    task automatic t_low_one;
        run_op("R4 bit40", 1, 3'd0, 64'h0000_0100_0000_0000, 64'd40);
        run_op("R4 bit63", 1, 3'd0, 64'h8000_0000_0000_0000, 64'd63);
        run_op("R4 R3 zero", 1, 3'd0, 64'h0, NONE);
        run_op("R4 R11 narrow", 0, 3'd0, 64'hFFFF_0000_0000_0008, 64'd3);
        run_op("R4 R11 narrow none", 0, 3'd0, 64'hFFFF_FFFF_0000_0000, NONE);
    endtask

    task automatic t_low_zero;
        run_op("R5 bit7", 1, 3'd1, 64'hFFFF_FFFF_FFFF_FF7F, 64'd7);
        run_op("R5 ones", 1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, NONE);
        run_op("R5 zero", 1, 3'd1, 64'h0, 64'd0);
        run_op("R5 R11 narrow ones", 0, 3'd1, 64'h0000_0000_FFFF_FFFF, NONE);
    endtask

    task automatic t_zero_cnt;
        run_op("R6 zero", 1, 3'd2, 64'h0, 64'd64);
        run_op("R6 ones", 1, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
        run_op("R6 R11 narrow", 0, 3'd2, 64'hFFFF_FFFF_0000_000F, 64'd28);
    endtask

    task automatic t_lead;
        run_op("R7 bit16", 1, 3'd3, 64'h0000_0000_0001_0000, 64'd47);
        run_op("R7 bit0", 1, 3'd3, 64'h1, 64'd63);
        run_op("R7 narrow", 0, 3'd3, 64'h0000_0000_0001_0000, 64'd15);
        run_op("R7 R11 narrow none", 0, 3'd3, 64'hFFFF_FFFF_0000_0000, NONE);
    endtask

    task automatic t_sign_run;
        run_op("R8 positive", 1, 3'd4, 64'h0000_0F00_0000_0000, 64'd20);
        run_op("R8 negative", 1, 3'd4, 64'hFFF0_0000_0000_0000, 64'd12);
        run_op("R8 narrow neg", 0, 3'd4, 64'h0000_0000_8000_0000, 64'd1);
        run_op("R8 ones", 1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, NONE);
        run_op("R8 narrow zero", 0, 3'd4, 64'h1234_5678_0000_0000, NONE);
    endtask

    task automatic t_quad;
        run_op("R9 wide", 1, 3'd5, 64'h1000_0200_0030_0001, 64'hF000_0F00_00F0_000F);
        run_op("R9 R11 narrow", 0, 3'd5, 64'hFFFF_FFFF_0000_0081, 64'h0000_0000_0000_00FF);
        run_op("R10 wide", 1, 3'd6, 64'h1000_0200_0030_0001, 64'h0000_0000_0000_8421);
        run_op("R10 R11 narrow", 0, 3'd6, 64'hFFFF_FFFF_F000_0001, 64'h0000_0000_0000_0081);
        run_op("R12 none op", 1, 3'd7, 64'h0000_0000_0000_1234, 64'h0);
    endtask

    task automatic t_hold;
        run_op("R2 load", 1, 3'd0, 64'h0000_0000_0000_0010, 64'd4);
        @(negedge clk);
        in_opcode = 3'd2; in_operand = 64'h0; in_wide = 1'b1;
        @(negedge clk);
        compare("R2 idle valid", {63'd0, out_valid}, 64'd0);
        compare("R2 idle hold", out_result, 64'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_low_one();
        t_low_zero();
        t_zero_cnt();
        t_lead();
        t_sign_run();
        t_quad();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule